// File: doc/BRIEF.md
# Multi-mode 16-bit capture timer

A 16-bit timer peripheral that sits behind a small word-wide register port. It has a counter, one register that serves as capture or reload register depending on mode, and a control register. Three operating modes are selected by software. Reload mode counts down, reloads on underflow, raises an event and toggles an output pin. Single-edge capture mode counts down and copies the live count when the chosen edge arrives on the input pin. Difference mode waits for a first edge, counts up from zero and freezes the elapsed interval into the capture register on the next chosen edge.

The input pin passes through a two-stage synchronizer, and edges are found by comparing the synchronized sample with the sample one clock older. Every timer event sets a sticky pending flag. The interrupt request is asserted while that flag and the enable bit are both set.

Register map (address on `bus_addr`): 0 is the counter, 1 is the capture/reload register, 2 is the control register, and 3 reads zero. Control bits: 0 run; 2:1 mode (00 reload, 01 capture, 10 difference, 11 hold); 3 edge select (1 rising, 0 falling); 4 interrupt enable; 5 pending (write 1 clears); 6 saturation flag (write 1 clears); 7 output start level on write, current output level on read.

Top module: `cap_timer16`

## Requirements
- R1: After reset the counter reads 0xFFFF, the capture/reload register reads 0x0000, control reads 0x00, and irq and t1_out are low.
- R2: Writes to address 0 or 1 load the counter or the capture/reload register. While the run bit is 0, the counter holds its value.
- R3: In reload mode (mode 00) with run set, the counter decrements once per clock. When it reaches 0, the next clock loads it from the capture/reload register, sets pending and inverts t1_out.
- R4: A control write that sets run while the timer is stopped loads t1_out from bit 7. A control write while the timer is running leaves t1_out unchanged.
- R5: In capture mode (mode 01), a selected edge on t1_in stores the counter value and sets pending. The stored value is the counter value seen just before the pin change, minus 2, because of the synchronizer latency. An edge of the other polarity changes neither the capture register nor pending.
- R6: Edge select bit 3 chooses the rising edge when 1 and the falling edge when 0. It applies to both capture modes.
- R7: In difference mode (mode 10), the first selected edge clears the counter, which then counts up once per clock. The next selected edge stores the count (the edge spacing in clocks minus 1) and sets pending. After that the counter and the capture register hold, and further edges are ignored until run is cleared.
- R8: In difference mode, a count that reaches 0xFFFF with no second edge stays at 0xFFFF and sets control bit 6. The bit stays set until software writes 1 to it.
- R9: Pending (bit 5) stays set until software writes a 1 to it. irq is high exactly when pending and enable (bit 4) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| t1_in | input | 1 | Asynchronous capture input pin |
| t1_out | output | 1 | Underflow toggle output |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the two-clock synchronizer latency in the captured value. A design that skipped a stage or sampled too late would store a count that is off by one or more. Difference intervals are measured at several spacings and with both polarities. An off-by-one start count or a wrong edge polarity shows up as a wrong stored interval, and a design that kept counting after the second edge would let a third edge overwrite the result. The saturation case runs the up-count past 65535 clocks, which catches a counter that wraps to zero or never raises the flag. Other directed cases cover the reload-and-toggle sequence, the output start level being ignored while running, and pending set with the enable bit off (a design that ignored the enable would raise irq).

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  typedef enum logic [1:0] {
    MD_RELOAD  = 2'b00,
    MD_CAPTURE = 2'b01,
    MD_DIFF    = 2'b10,
    MD_HOLD    = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    DF_WAIT  = 2'b00,
    DF_COUNT = 2'b01,
    DF_DONE  = 2'b10
  } diff_state_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CAP  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/ctm_edge_sync.sv
module ctm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign cur = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign edge_hit = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (!edge_hit || !$stable(rise_sel)));
endmodule

// File: rtl/ctm_core.sv
module ctm_core
  import ctm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  tmr_mode_e    mode,
  input  logic         edge_hit,
  input  logic         cnt_wr,
  input  logic         cap_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cap_q,
  output logic         evt,
  output logic         sat_evt,
  output logic         toggle
);
  localparam logic [W-1:0] CNT_MAX  = '1;
  localparam logic [W-1:0] CNT_ZERO = '0;
  localparam logic [W-1:0] CNT_ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d, cap_d;
  diff_state_e  st_q, st_d;
  logic         upd_en;

  assign upd_en = run | cnt_wr | cap_wr;

  always_comb begin
    cnt_d   = cnt_q;
    cap_d   = cap_q;
    st_d    = st_q;
    evt     = 1'b0;
    sat_evt = 1'b0;
    toggle  = 1'b0;
    if (!run || mode != MD_DIFF) st_d = DF_WAIT;
    if (run) begin
      case (mode)
        MD_RELOAD: begin
          if (cnt_q == CNT_ZERO) begin
            cnt_d  = cap_q;
            evt    = 1'b1;
            toggle = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        MD_CAPTURE: begin
          cnt_d = cnt_q - CNT_ONE;
          if (edge_hit) begin
            cap_d = cnt_q;
            evt   = 1'b1;
          end
        end
        MD_DIFF: begin
          case (st_q)
            DF_WAIT: if (edge_hit) begin
              cnt_d = CNT_ZERO;
              st_d  = DF_COUNT;
            end
            DF_COUNT: begin
              if (edge_hit) begin
                cap_d = cnt_q;
                evt   = 1'b1;
                st_d  = DF_DONE;
              end else if (cnt_q == CNT_MAX) begin
                sat_evt = 1'b1;
              end else begin
                cnt_d = cnt_q + CNT_ONE;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (cnt_wr) cnt_d = wdata;
    if (cap_wr) cap_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MAX;
      cap_q <= CNT_ZERO;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DF_WAIT;
    else        st_q <= st_d;
  end

  // R3
  reload_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MD_RELOAD && cnt_q != CNT_ZERO && !cnt_wr)
      |=> cnt_q == $past(cnt_q) - CNT_ONE);

  // R5
  capture_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MD_CAPTURE && edge_hit && !cap_wr) |=> cap_q == $past(cnt_q));

  // R7
  diff_done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MD_DIFF && st_q == DF_DONE && !cnt_wr && !cap_wr)
      |=> ($stable(cnt_q) && $stable(cap_q)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MD_DIFF && st_q == DF_COUNT && cnt_q == CNT_MAX && !edge_hit && !cnt_wr)
      |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import ctm_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         t1_in,
  output logic         t1_out,
  output logic         irq
);
  localparam int CTRL_W = 8;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic      run_q, edge_q, ie_q, pend_q, ovf_q, out_q;
  tmr_mode_e mode_q;
  logic      run_d, edge_d, ie_d, pend_d, ovf_d, out_d;
  tmr_mode_e mode_d;
  logic      ctrl_wr, ctrl_en;

  logic         edge_hit, core_evt, core_sat, core_toggle;
  logic [W-1:0] cnt_q, cap_q;

  ctm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin      (t1_in),
    .rise_sel (edge_q),
    .edge_hit (edge_hit)
  );

  ctm_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_q),
    .mode     (mode_q),
    .edge_hit (edge_hit),
    .cnt_wr   (bus_wr && bus_addr == ADDR_CNT),
    .cap_wr   (bus_wr && bus_addr == ADDR_CAP),
    .wdata    (bus_wdata),
    .cnt_q    (cnt_q),
    .cap_q    (cap_q),
    .evt      (core_evt),
    .sat_evt  (core_sat),
    .toggle   (core_toggle)
  );

  assign ctrl_wr = bus_wr && bus_addr == ADDR_CTRL;
  assign ctrl_en = ctrl_wr | core_evt | core_sat | core_toggle;

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    edge_d = edge_q;
    ie_d   = ie_q;
    pend_d = pend_q;
    ovf_d  = ovf_q;
    out_d  = out_q;
    if (ctrl_wr) begin
      run_d  = bus_wdata[0];
      mode_d = tmr_mode_e'(bus_wdata[2:1]);
      edge_d = bus_wdata[3];
      ie_d   = bus_wdata[4];
      if (bus_wdata[5]) pend_d = 1'b0;
      if (bus_wdata[6]) ovf_d  = 1'b0;
      if (!run_q && bus_wdata[0]) out_d = bus_wdata[7];
    end
    if (core_toggle) out_d  = ~out_q;
    if (core_evt)    pend_d = 1'b1;
    if (core_sat)    ovf_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      mode_q <= MD_RELOAD;
      edge_q <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      out_q  <= 1'b0;
    end else if (ctrl_en) begin
      run_q  <= run_d;
      mode_q <= mode_d;
      edge_q <= edge_d;
      ie_q   <= ie_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
      out_q  <= out_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CNT:  bus_rdata = cnt_q;
      ADDR_CAP:  bus_rdata = cap_q;
      ADDR_CTRL: bus_rdata = {{(W-CTRL_W){1'b0}}, out_q, ovf_q, pend_q, ie_q,
                              edge_q, mode_q, run_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign t1_out = out_q;
  assign irq    = pend_q & ie_q;

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_evt |=> pend_q);

  // R3
  out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_toggle |=> t1_out != $past(t1_out));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_q && !(ctrl_wr && bus_wdata[6])) |=> ovf_q);
endmodule

// File: tb/cap_timer16_test.sv
`timescale 1ns/1ps
module cap_timer16_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        t1_in;
  logic        t1_out;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cap_timer16 uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .t1_in     (t1_in),
    .t1_out    (t1_out),
    .irq       (irq)
  );

  // {edge_rising, edge spacing in clocks, expected stored interval}
  localparam logic [32:0] DIFF_TAB [6] = '{
    {1'b1, 16'd4,   16'd3},
    {1'b1, 16'd5,   16'd4},
    {1'b0, 16'd7,   16'd6},
    {1'b1, 16'd20,  16'd19},
    {1'b0, 16'd100, 16'd99},
    {1'b0, 16'd4,   16'd3}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, c0, c1;
    logic        act, rest;
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 16'h0; t1_in = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 counter", v, 16'hFFFF);
    rd_reg(2'd1, v); chk("R1 capture", v, 16'h0000);
    rd_reg(2'd2, v); chk("R1 control", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 t1_out", {15'd0, t1_out}, 16'd0);

    // R3 reload mode with R4 start level high, R9 enable on
    bus_write(2'd1, 16'd3);
    bus_write(2'd0, 16'd2);
    rd_reg(2'd0, v); chk("R2 counter load", v, 16'd2);
    bus_write(2'd2, 16'h0091);
    rd_reg(2'd0, v); chk("R3 count start", v, 16'd2);
    chk("R4 start level high", {15'd0, t1_out}, 16'd1);
    wait_n(2);
    rd_reg(2'd0, v); chk("R3 reached zero", v, 16'd0);
    chk("R9 irq before underflow", {15'd0, irq}, 16'd0);
    wait_n(1);
    rd_reg(2'd0, v); chk("R3 reload value", v, 16'd3);
    chk("R9 irq on underflow", {15'd0, irq}, 16'd1);
    chk("R3 first toggle", {15'd0, t1_out}, 16'd0);
    wait_n(4);
    rd_reg(2'd0, v); chk("R3 second reload", v, 16'd3);
    chk("R3 second toggle", {15'd0, t1_out}, 16'd1);
    chk("R9 pending sticky", {15'd0, irq}, 16'd1);
    bus_write(2'd2, 16'h0031);
    chk("R9 pending cleared", {15'd0, irq}, 16'd0);
    chk("R4 level kept while running", {15'd0, t1_out}, 16'd1);

    // R2 stop holds counter
    bus_write(2'd2, 16'h0000);
    rd_reg(2'd0, c0);
    wait_n(5);
    rd_reg(2'd0, v); chk("R2 stopped holds", v, c0);

    // R9 pending with enable off; R4 start level low
    bus_write(2'd1, 16'd5);
    bus_write(2'd0, 16'd0);
    bus_write(2'd2, 16'h0001);
    chk("R4 start level low", {15'd0, t1_out}, 16'd0);
    wait_n(1);
    rd_reg(2'd2, v); chk("R9 pending bit without enable", v & 16'h0020, 16'h0020);
    chk("R9 irq masked", {15'd0, irq}, 16'd0);
    bus_write(2'd2, 16'h0020);

    // R5 capture, rising edge
    bus_write(2'd2, 16'h000B);
    wait_n(3);
    rd_reg(2'd0, c0);
    t1_in = 1'b1;
    wait_n(4);
    rd_reg(2'd1, v); chk("R5 capture rising", v, c0 - 16'd2);
    rd_reg(2'd2, c1); chk("R5 pending set", c1 & 16'h0020, 16'h0020);
    bus_write(2'd2, 16'h002B);
    t1_in = 1'b0;
    wait_n(4);
    rd_reg(2'd1, c1); chk("R5 falling ignored capture", c1, v);
    rd_reg(2'd2, c1); chk("R5 falling ignored pending", c1 & 16'h0020, 16'h0000);

    // R6 falling select
    bus_write(2'd2, 16'h0003);
    t1_in = 1'b1;
    wait_n(4);
    rd_reg(2'd2, c1); chk("R6 rising ignored when falling selected", c1 & 16'h0020, 16'h0000);
    rd_reg(2'd0, c0);
    t1_in = 1'b0;
    wait_n(4);
    rd_reg(2'd1, v); chk("R6 capture falling", v, c0 - 16'd2);

    // R7 difference capture table
    foreach (DIFF_TAB[k]) begin
      act  = DIFF_TAB[k][32];
      rest = ~act;
      bus_write(2'd2, 16'h0020);
      t1_in = rest;
      wait_n(4);
      bus_write(2'd2, act ? 16'h000D : 16'h0005);
      wait_n(2);
      for (int i = 0; i <= int'(DIFF_TAB[k][31:16]); i++) begin
        @(negedge clk);
        if (i == 0) t1_in = act;
        if (i == 2) t1_in = rest;
        if (i == int'(DIFF_TAB[k][31:16])) t1_in = act;
      end
      wait_n(4);
      rd_reg(2'd1, v); chk($sformatf("R7 interval entry %0d", k), v, DIFF_TAB[k][15:0]);
      rd_reg(2'd2, c1); chk($sformatf("R7 pending entry %0d", k), c1 & 16'h0020, 16'h0020);
      t1_in = rest;
      wait_n(3);
      t1_in = act;
      wait_n(4);
      rd_reg(2'd1, v); chk($sformatf("R7 later edge ignored %0d", k), v, DIFF_TAB[k][15:0]);
      rd_reg(2'd0, v); chk($sformatf("R7 counter stopped %0d", k), v, DIFF_TAB[k][15:0]);
    end

    // R8 saturation
    bus_write(2'd2, 16'h0020);
    t1_in = 1'b0;
    wait_n(4);
    bus_write(2'd2, 16'h000D);
    wait_n(2);
    t1_in = 1'b1;
    wait_n(2);
    t1_in = 1'b0;
    wait_n(65540);
    rd_reg(2'd0, v); chk("R8 saturated counter", v, 16'hFFFF);
    rd_reg(2'd2, v); chk("R8 flag set", v & 16'h0060, 16'h0040);
    t1_in = 1'b1;
    wait_n(4);
    rd_reg(2'd1, v); chk("R8 capture after saturation", v, 16'hFFFF);
    rd_reg(2'd2, v); chk("R8 flag still set", v & 16'h0040, 16'h0040);
    bus_write(2'd2, 16'h004D);
    rd_reg(2'd2, v); chk("R8 flag cleared", v & 16'h0040, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule